// File: doc/BRIEF.md
# Event Counter Bank

A bank of eight event counters for an uncore agent, programmed and read through a 32-bit register port. Each counter has its own 8-bit event code. The code picks one line from a bus of event strobes. A counter advances by one on each clock in which its selected strobe is high, its own enable bit is set and the bank-wide enable bit is set.

A counter is 64 bits wide. It is accessed as two 32-bit words: the low word sits at the counter's base offset and the high word four bytes above it. A build parameter selects the narrow variant, in which only 48 bits are live.

When a counter wraps from its top value to zero, it sets its own bit in an overflow status register. The status bits are combined with a mask register to drive one interrupt line. Software clears a status bit by writing one to that bit in a separate clear register.

Top module: `evt_counter_bank`

## Requirements
- R1: After reset, every counter reads 0 and the overflow status reads 0. The mask register (0x0800) reads 0xFF. Both event-code registers read 0xFFFFFFFF. The interrupt is low.
- R2: Counter n advances by exactly 1 on each clock in which its selected strobe is high, bit n of the counter-enable register (0x1C00) is 1 and bit 16 of the control register (0x0408) is 1. With bit n of 0x1C00 clear, the counter does not advance.
- R3: While bit 16 of 0x0408 is 0, no counter advances and every counter keeps its value.
- R4: The codes for counters 0 to 3 sit in 0x1D00 and the codes for counters 4 to 7 sit in 0x1D04. Counter n's code occupies bits [8*(n%4)+7 : 8*(n%4)]. A code c below 16 selects strobe line c. Code 0xFF, and any code of 16 or more, never counts.
- R5: Counter n's low word is at 0x1E00+8n and its high word is at 0x1E04+8n. A register write to a counter takes priority over an increment in the same cycle.
- R6: In the 48-bit variant, bits [63:48] of a counter always read 0, writes to those bits have no effect, and the top value is 2^48-1.
- R7: When a counter advances from its top value it becomes 0 and sets bit n of the status register (0x0808). Writes to 0x0808 have no effect.
- R8: Writing 1 to bit n of 0x080C clears status bit n, and writing 0 leaves it unchanged. If an overflow and a clear of the same bit land in one cycle, the bit ends up set.
- R9: The interrupt is high exactly when some status bit is 1 and the matching mask bit is 0.
- R10: The version register at 0x1CF0 reads the build constant and ignores writes. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 16 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe for the current cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| evt_in | input | 16 | Event strobe lines, one per selectable source |
| irq | output | 1 | Overflow interrupt, high while an unmasked status bit is set |

## Verification
Read data is combinational from registered state, so a write or an event strobe at one rising edge is visible on reg_rdata in the same half cycle that follows. The bench drives inputs at the falling edge and lets exactly one rising edge pass. It then samples one nanosecond after the next falling edge. Status bits and the interrupt change at the same edge as the counter wrap, because the interrupt is derived combinationally from the status and mask registers. The overflow check therefore reads the counter, the status register and irq together after the single event edge. The cases where a write and an event, or an overflow and a clear, arrive together are driven in one shared cycle and read back in the next.

// File: rtl/evb_pkg.sv
// Shared constants for the event counter bank: register offsets,
// field positions and the reserved event code.
// Assumes word-aligned 32-bit accesses on a 16-bit byte address.
package evb_pkg;
    localparam int          ADDR_W     = 16;
    localparam int          CODE_W     = 8;
    localparam int          GLB_EN_BIT = 16;
    localparam logic [15:0] OFF_CTRL   = 16'h0408;
    localparam logic [15:0] OFF_MASK   = 16'h0800;
    localparam logic [15:0] OFF_STAT   = 16'h0808;
    localparam logic [15:0] OFF_CLR    = 16'h080C;
    localparam logic [15:0] OFF_EVCTL  = 16'h1C00;
    localparam logic [15:0] OFF_VER    = 16'h1CF0;
    localparam logic [15:0] OFF_CODE   = 16'h1D00;
    localparam logic [15:0] OFF_CNT    = 16'h1E00;
    localparam logic [7:0]  CODE_NONE  = 8'hFF;
endpackage

// File: rtl/evb_evsel.sv
// Event selector: picks one strobe line by event code.
// Assumes codes at or above NUM_SRC, and the reserved "none" code, select nothing.
module evb_evsel
    import evb_pkg::*;
#(
    parameter int NUM_SRC = 16
) (
    input  logic [NUM_SRC-1:0] src,
    input  logic [CODE_W-1:0]  code,
    output logic               hit
);
    localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    // choose the strobe named by the code, or none
    always_comb begin
        hit = 1'b0;
        if (code != CODE_NONE && int'(code) < NUM_SRC)
            hit = src[code[SEL_W-1:0]];
    end
endmodule

// File: rtl/evb_counter.sv
// One event counter with a two-word write port and wrap detection.
// Assumes the upper bits above ACT_W are held at zero and never written.
module evb_counter #(
    parameter int ACT_W = 48
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        inc,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    output logic [63:0] cnt,
    output logic        ovf
);
    localparam logic [63:0] ACT_MASK = (ACT_W >= 64) ? {64{1'b1}} :
                                       ((64'd1 << ACT_W) - 64'd1);

    // register writes take priority over increments
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (wr_lo)
            cnt[31:0] <= wdata;
        else if (wr_hi)
            cnt[63:32] <= wdata & ACT_MASK[63:32];
        else if (inc)
            cnt <= (cnt + 64'd1) & ACT_MASK;
    end

    // wrap flag: an increment taken from the top value
    assign ovf = inc && !wr_lo && !wr_hi && (cnt == ACT_MASK);

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !wr_lo && !wr_hi) |=> $stable(cnt));

    // R7
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (cnt == 64'd0));

    // R5
    wr_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (cnt[31:0] == $past(wdata)));
endmodule

// File: rtl/evb_irq.sv
// Overflow status register with write-one-to-clear and masked interrupt.
// Assumes a set in the same cycle as a clear of that bit wins.
module evb_irq #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_vec,
    input  logic [N-1:0] mask,
    output logic [N-1:0] status,
    output logic         irq
);
    logic [N-1:0] clr_eff;
    assign clr_eff = clr_wr ? clr_vec : '0;

    // sticky status: clear first, then apply new overflows
    always_ff @(posedge clk) begin
        if (!rst_n)
            status <= '0;
        else
            status <= (status & ~clr_eff) | set_vec;
    end

    // interrupt from unmasked status bits
    assign irq = |(status & ~mask);

    // R7
    set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((status & $past(set_vec)) == $past(set_vec)));

    // R8
    clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((status & $past(clr_vec & ~set_vec)) == '0));
endmodule

// File: rtl/evt_counter_bank.sv
// Event counter bank top: register decode, configuration registers,
// per-counter selectors and counters, overflow status and interrupt.
// Assumes word-aligned accesses, NUM_CNT a multiple of 4 and at most 8.
module evt_counter_bank
    import evb_pkg::*;
#(
    parameter int          NUM_CNT    = 8,
    parameter int          NUM_SRC    = 16,
    parameter bit          WIDE       = 1'b0,
    parameter logic [31:0] VERSION_ID = 32'h0000_0021
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [NUM_SRC-1:0] evt_in,
    output logic               irq
);
    localparam int ACT_W = WIDE ? 64 : 48;

    logic               glb_en_q;
    logic [NUM_CNT-1:0] cnt_en_q;
    logic [NUM_CNT-1:0] mask_q;
    logic [CODE_W-1:0]  code_q  [NUM_CNT];
    logic [63:0]        cnt_val [NUM_CNT];
    logic [NUM_CNT-1:0] hit_vec;
    logic [NUM_CNT-1:0] ovf_vec;
    logic [NUM_CNT-1:0] status;
    logic               clr_wr;

    // configuration registers: global enable, counter enables, mask, codes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glb_en_q <= 1'b0;
            cnt_en_q <= '0;
            mask_q   <= '1;
            for (int n = 0; n < NUM_CNT; n++) code_q[n] <= CODE_NONE;
        end else if (reg_wr) begin
            if (reg_addr == OFF_CTRL)  glb_en_q <= reg_wdata[GLB_EN_BIT];
            if (reg_addr == OFF_EVCTL) cnt_en_q <= reg_wdata[NUM_CNT-1:0];
            if (reg_addr == OFF_MASK)  mask_q   <= reg_wdata[NUM_CNT-1:0];
            for (int n = 0; n < NUM_CNT; n++)
                if (reg_addr == OFF_CODE + ADDR_W'(4 * (n / 4)))
                    code_q[n] <= reg_wdata[8*(n%4) +: 8];
        end
    end

    generate
        for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
            evb_evsel #(.NUM_SRC(NUM_SRC)) u_sel (
                .src  (evt_in),
                .code (code_q[g]),
                .hit  (hit_vec[g])
            );
            evb_counter #(.ACT_W(ACT_W)) u_ctr (
                .clk   (clk),
                .rst_n (rst_n),
                .inc   (glb_en_q && cnt_en_q[g] && hit_vec[g]),
                .wr_lo (reg_wr && reg_addr == OFF_CNT + ADDR_W'(8 * g)),
                .wr_hi (reg_wr && reg_addr == OFF_CNT + ADDR_W'(8 * g + 4)),
                .wdata (reg_wdata),
                .cnt   (cnt_val[g]),
                .ovf   (ovf_vec[g])
            );
        end
    endgenerate

    assign clr_wr = reg_wr && (reg_addr == OFF_CLR);

    evb_irq #(.N(NUM_CNT)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (ovf_vec),
        .clr_wr  (clr_wr),
        .clr_vec (reg_wdata[NUM_CNT-1:0]),
        .mask    (mask_q),
        .status  (status),
        .irq     (irq)
    );

    // read mux: fixed registers, packed code words, counter halves
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFF_CTRL:  reg_rdata[GLB_EN_BIT]  = glb_en_q;
            OFF_MASK:  reg_rdata[NUM_CNT-1:0] = mask_q;
            OFF_STAT:  reg_rdata[NUM_CNT-1:0] = status;
            OFF_EVCTL: reg_rdata[NUM_CNT-1:0] = cnt_en_q;
            OFF_VER:   reg_rdata              = VERSION_ID;
            default:   ;
        endcase
        for (int n = 0; n < NUM_CNT; n++) begin
            if (reg_addr == OFF_CODE + ADDR_W'(4 * (n / 4)))
                reg_rdata[8*(n%4) +: 8] = code_q[n];
            if (reg_addr == OFF_CNT + ADDR_W'(8 * n))
                reg_rdata = cnt_val[n][31:0];
            if (reg_addr == OFF_CNT + ADDR_W'(8 * n + 4))
                reg_rdata = cnt_val[n][63:32];
        end
    end

    // R10
    ver_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFF_VER) |-> (reg_rdata == VERSION_ID));

    // R9
    mask_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_q) |-> !irq);
endmodule

// File: tb/evt_counter_bank_bench.sv
// Directed bench for the event counter bank, one task per scenario.
module evt_counter_bank_bench;
    localparam logic [31:0] VER = 32'h0000_0021;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] evt_in = '0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    evt_counter_bank #(.VERSION_ID(VER)) u_evt_counter_bank (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in), .irq(irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic wr_evt(input logic [15:0] a, input logic [31:0] d, input logic [15:0] e);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1; evt_in = e;
        @(posedge clk); #1;
        reg_wr = 1'b0; evt_in = '0;
    endtask

    task automatic pulse(input logic [15:0] e);
        @(negedge clk);
        evt_in = e;
        @(posedge clk); #1;
        evt_in = '0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [15:0] lo(input int n);
        return 16'h1E00 + 16'(8 * n);
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        rd(lo(0), d);      chk("R1 cnt0", 64'(d), 64'd0);
        rd(lo(7) + 4, d);  chk("R1 cnt7 hi", 64'(d), 64'd0);
        rd(16'h0800, d);   chk("R1 mask", 64'(d), 64'hFF);
        rd(16'h1D00, d);   chk("R1 code0", 64'(d), 64'hFFFF_FFFF);
        rd(16'h1D04, d);   chk("R1 code1", 64'(d), 64'hFFFF_FFFF);
        rd(16'h0808, d);   chk("R1 status", 64'(d), 64'd0);
        chk("R1 irq", 64'(irq), 64'd0);
    endtask

    task automatic t_count();
        logic [31:0] d;
        wr(16'h1D00, 32'h0302_0100);
        wr(16'h1D04, 32'hFFFF_FF05);
        wr(16'h1C00, 32'hFF);
        wr(16'h0408, 32'h0001_0000);
        for (int i = 0; i < 3; i++) pulse(16'h0001);
        rd(lo(0), d); chk("R2 cnt0 three", 64'(d), 64'd3);
        rd(lo(1), d); chk("R2 cnt1 idle", 64'(d), 64'd0);
        pulse(16'h0022);
        rd(lo(1), d); chk("R4 cnt1 src1", 64'(d), 64'd1);
        rd(lo(4), d); chk("R4 cnt4 src5", 64'(d), 64'd1);
        pulse(16'hFFFF);
        rd(lo(5), d); chk("R4 code FF none", 64'(d), 64'd0);
        rd(lo(2), d); chk("R4 cnt2", 64'(d), 64'd1);
        rd(lo(0), d); chk("R2 cnt0 four", 64'(d), 64'd4);
        wr(16'h1C00, 32'hFE);
        pulse(16'h0001);
        rd(lo(0), d); chk("R2 per-counter enable off", 64'(d), 64'd4);
        wr(16'h1C00, 32'hFF);
    endtask

    task automatic t_global();
        logic [31:0] d;
        wr(16'h0408, 32'h0);
        pulse(16'hFFFF);
        rd(lo(0), d); chk("R3 held cnt0", 64'(d), 64'd4);
        rd(lo(4), d); chk("R3 held cnt4", 64'(d), 64'd2);
        wr(16'h0408, 32'h0001_0000);
        pulse(16'h0001);
        rd(lo(0), d); chk("R2 resumes", 64'(d), 64'd5);
        wr(16'h1D00, 32'h0310_0100);
        rd(16'h1D00, d); chk("R4 code readback", 64'(d), 64'h0310_0100);
        pulse(16'hFFFF);
        rd(lo(2), d); chk("R4 code out of range", 64'(d), 64'd1);
        rd(lo(0), d); chk("R2 cnt0 six", 64'(d), 64'd6);
    endtask

    task automatic t_access();
        logic [31:0] d;
        wr(lo(3), 32'h1234_5678);
        wr(lo(3) + 4, 32'hABCD_EF01);
        rd(lo(3), d);     chk("R5 low word", 64'(d), 64'h1234_5678);
        rd(lo(3) + 4, d); chk("R6 upper bits zero", 64'(d), 64'h0000_EF01);
        wr_evt(lo(0), 32'h0000_0100, 16'h0001);
        rd(lo(0), d); chk("R5 write wins", 64'(d), 64'h100);
    endtask

    task automatic t_ovf();
        logic [31:0] d;
        wr(lo(0), 32'hFFFF_FFFF);
        wr(lo(0) + 4, 32'h0000_FFFF);
        pulse(16'h0001);
        rd(lo(0), d);     chk("R6 wrap at 48 lo", 64'(d), 64'd0);
        rd(lo(0) + 4, d); chk("R6 wrap at 48 hi", 64'(d), 64'd0);
        rd(16'h0808, d);  chk("R7 status set", 64'(d), 64'h1);
        chk("R9 masked irq", 64'(irq), 64'd0);
        wr(16'h0808, 32'h0);
        rd(16'h0808, d);  chk("R7 status read-only", 64'(d), 64'h1);
        wr(16'h0800, 32'hFE);
        rd(16'h0808, d);  chk("R9 irq unmasked", 64'(irq), 64'd1);
        wr(16'h080C, 32'h02);
        rd(16'h0808, d);  chk("R8 zero keeps", 64'(d), 64'h1);
        wr(16'h080C, 32'h01);
        rd(16'h0808, d);  chk("R8 one clears", 64'(d), 64'h0);
        chk("R9 irq drops", 64'(irq), 64'd0);
        wr(lo(0), 32'hFFFF_FFFF);
        wr(lo(0) + 4, 32'h0000_FFFF);
        wr_evt(16'h080C, 32'h01, 16'h0001);
        rd(16'h0808, d);  chk("R8 set beats clear", 64'(d), 64'h1);
        chk("R9 irq on again", 64'(irq), 64'd1);
    endtask

    task automatic t_misc();
        logic [31:0] d;
        rd(16'h1CF0, d); chk("R10 version", 64'(d), 64'(VER));
        wr(16'h1CF0, 32'hDEAD_BEEF);
        rd(16'h1CF0, d); chk("R10 version read-only", 64'(d), 64'(VER));
        rd(16'h0100, d); chk("R10 unmapped", 64'(d), 64'd0);
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_count();
        t_global();
        t_access();
        t_ovf();
        t_misc();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule